// File: doc/BRIEF.md
# I2C Serial Memory Slave Engine

This block is the bus-facing half of a 2 KB serial memory. It oversamples the two I2C wires with the system clock and finds START, repeated START and STOP. It shifts bytes in and out and answers each received byte with an acknowledge. The first byte after a START is a device select. Its upper nibble is a fixed type code. Its next three bits are the top three bits of the 11-bit memory address, and its last bit selects read or write. A write carries one byte address and then data bytes. Those bytes go out on a simple byte-wide memory port.

Reads can start from the internal address counter (current read) or from an address loaded by an aborted write (random read). A read continues for as long as the master acknowledges. A write engine outside the block raises `busy_i` while it programs the cells. During that time the block leaves the bus alone, so a master can poll for completion by watching for an acknowledge. The open-drain SDA driver is modelled by `sda_oe`: when it is high the line is pulled low.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset `sda_oe`, `mem_we` and `mem_re` are low, and the block does not drive SDA until it has received a START.
- R2: A device select byte whose upper nibble is 1010 (sent MSB first) is acknowledged by pulling SDA low during the ninth clock. Any other code gets no acknowledge, and later bytes are ignored until the next START.
- R3: In a write, the device select (bit 0 = 0, bits 3:1 = address bits 10:8) and the byte address are both acknowledged. Each data byte is acknowledged and stored by exactly one single-cycle `mem_we` pulse at the address formed from those fields.
- R4: During a write the address advances only in its low four bits, so bytes past the end of a 16-byte row wrap to the start of the same row.
- R5: A current read (bit 0 = 1) returns the byte at the internal address counter, and the counter then advances by one.
- R6: A random read is a write carrying only a byte address, followed by a repeated START and a read select. It returns the byte at the loaded address.
- R7: A read continues to consecutive addresses while the master acknowledges each byte, and the counter wraps from 7FFh to 000h.
- R8: When the master does not acknowledge a read byte, the block releases SDA and ignores further clocks until the next START.
- R9: While `busy_i` is high the block acknowledges nothing and writes nothing. Once it drops, a device select is acknowledged normally.
- R10: A START is recognised in any state, including in the middle of a byte, and begins a fresh device select.
- R11: The block starts pulling SDA low only while the sampled SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| busy_i | input | 1 | Write engine is programming; ignore the bus |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_we | output | 1 | One-cycle write strobe |
| mem_wdata | output | 8 | Write data |
| mem_re | output | 1 | One-cycle read strobe; data is expected the next cycle |
| mem_rdata | input | 8 | Read data from the memory |

## Verification
The hardest situations to reach are the ones where the master abandons a protocol step. Examples are a read byte left without an acknowledge, a START cut into half a byte, and a device select sent while the write engine is busy. The bench plays the master cycle by cycle, so it can break a byte after four bits or hold `busy_i` across a complete select byte. After a refused read it keeps toggling SCL and counts any cycle in which the block pulls SDA low. This proves the block stays silent until a new START.

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter int ADDR_W   = 11,
  parameter int ROW_W    = 4,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata
);
  localparam int HI_W = ADDR_W - 8;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_ADDR, S_WDATA, S_RDATA} state_t;

  state_t state, nxt;
  logic [1:0] scl_q, sda_q;
  logic scl_p, sda_p;
  logic [3:0] bitcnt;
  logic [7:0] shreg, tx;
  logic ackph, mack, oe, we_r, re_r;
  logic [ADDR_W-1:0] addr;
  logic [7:0] wdata;

  wire scl_s    = scl_q[1];
  wire sda_s    = sda_q[1];
  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire start    = scl_s & scl_p & sda_p & ~sda_s;
  wire stop     = scl_s & scl_p & ~sda_p & sda_s;
  wire byte_end = (bitcnt == 4'd8);

  assign sda_oe    = oe;
  assign mem_addr  = addr;
  assign mem_we    = we_r;
  assign mem_wdata = wdata;
  assign mem_re    = re_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 2'b11;
      sda_q <= 2'b11;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_i};
      sda_q <= {sda_q[0], sda_i};
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      nxt    <= S_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      tx     <= '0;
      ackph  <= 1'b0;
      mack   <= 1'b0;
      oe     <= 1'b0;
      we_r   <= 1'b0;
      re_r   <= 1'b0;
      addr   <= '0;
      wdata  <= '0;
    end else begin
      we_r <= 1'b0;
      re_r <= 1'b0;
      if (we_r)
        addr[ROW_W-1:0] <= addr[ROW_W-1:0] + 1'b1;

      if (busy_i) begin
        state  <= S_IDLE;
        ackph  <= 1'b0;
        bitcnt <= '0;
        oe     <= 1'b0;
      end else if (start) begin
        state  <= S_DEV;
        ackph  <= 1'b0;
        bitcnt <= '0;
        oe     <= 1'b0;
      end else if (stop) begin
        state <= S_IDLE;
        ackph <= 1'b0;
        oe    <= 1'b0;
      end else if (state == S_RDATA) begin
        if (scl_rise) begin
          if (ackph) mack <= ~sda_s;
          else       bitcnt <= bitcnt + 1'b1;
        end
        if (scl_fall) begin
          if (ackph) begin
            ackph <= 1'b0;
            if (mack) begin
              tx     <= mem_rdata;
              oe     <= ~mem_rdata[7];
              bitcnt <= '0;
            end else begin
              state <= S_IDLE;
            end
          end else if (byte_end) begin
            oe    <= 1'b0;
            ackph <= 1'b1;
            addr  <= addr + 1'b1;
            re_r  <= 1'b1;
          end else begin
            tx <= {tx[6:0], 1'b0};
            oe <= ~tx[6];
          end
        end
      end else if (state != S_IDLE) begin
        if (scl_rise && !ackph && !byte_end) begin
          shreg  <= {shreg[6:0], sda_s};
          bitcnt <= bitcnt + 1'b1;
        end
        if (scl_fall) begin
          if (ackph) begin
            ackph  <= 1'b0;
            bitcnt <= '0;
            state  <= nxt;
            if (nxt == S_RDATA) begin
              tx <= mem_rdata;
              oe <= ~mem_rdata[7];
            end else begin
              oe <= 1'b0;
            end
          end else if (byte_end) begin
            case (state)
              S_DEV: begin
                if (shreg[7:4] == DEV_CODE) begin
                  oe    <= 1'b1;
                  ackph <= 1'b1;
                  if (shreg[0]) begin
                    nxt  <= S_RDATA;
                    re_r <= 1'b1;
                  end else begin
                    nxt <= S_ADDR;
                    addr[ADDR_W-1:8] <= shreg[HI_W:1];
                  end
                end else begin
                  state <= S_IDLE;
                end
              end
              S_ADDR: begin
                oe         <= 1'b1;
                ackph      <= 1'b1;
                addr[7:0]  <= shreg;
                nxt        <= S_WDATA;
              end
              default: begin
                oe    <= 1'b1;
                ackph <= 1'b1;
                we_r  <= 1'b1;
                wdata <= shreg;
                nxt   <= S_WDATA;
              end
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic busy_i,
  input logic sda_oe,
  input logic mem_we,
  input logic mem_re,
  input logic scl_s
);
  AST_WE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);  // R3

  AST_WE_RE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));  // R3

  AST_RE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> !mem_re);  // R5

  AST_BUSY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> !sda_oe);  // R9

  AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> !mem_we);  // R9

  AST_DRIVE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);  // R11
endmodule

bind i2c_mem_slave i2c_mem_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .sda_oe(sda_oe),
  .mem_we(mem_we), .mem_re(mem_re), .scl_s(scl_s)
);

// File: tb/i2c_mem_slave_tb.sv
module i2c_mem_slave_tb;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic busy = 1'b0;
  logic sda_oe, mem_we, mem_re;
  logic [10:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'h00;
  wire sda_bus = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  i2c_mem_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .busy_i(busy), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  logic [7:0] mem [0:2047];
  logic [7:0] ref_mem [0:2047];
  int checks = 0, errors = 0, oe_seen = 0, oe_bad = 0;
  logic [10:0] cur = '0;
  logic prev_oe = 1'b0;

  initial
    for (int i = 0; i < 2048; i++) begin
      mem[i]     = 8'(i) ^ 8'h5A ^ {5'd0, 3'(i >> 8)};
      ref_mem[i] = mem[i];
    end

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
    prev_oe <= sda_oe;
    if (sda_oe) oe_seen <= oe_seen + 1;
    if (sda_oe && !prev_oe && scl_m) oe_bad <= oe_bad + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic i_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(Q); scl_m = 1'b1; wq(2 * Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); ack = ~sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl_m = 1'b1; wq(Q); d[i] = sda_bus; wq(Q); scl_m = 1'b0;
    end
    wq(1); sda_m = ~give_ack; wq(Q); scl_m = 1'b1; wq(2 * Q); scl_m = 1'b0; wq(2);
    sda_m = 1'b1;
  endtask

  task automatic write_run(input logic [10:0] a, input logic [7:0] d0, input int n, input string tag);
    logic ack;
    logic [10:0] wa;
    i_start();
    send_byte({4'b1010, a[10:8], 1'b0}, ack); chk(ack, {tag, " select ack"}, ack, 1);
    send_byte(a[7:0], ack);                   chk(ack, {tag, " addr ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(d0 + 8'(k), ack);             chk(ack, {tag, " data ack"}, ack, 1);
      wa = {a[10:4], 4'(a[3:0] + 4'(k))};
      ref_mem[wa] = d0 + 8'(k);
    end
    i_stop();
    cur = {a[10:4], 4'(a[3:0] + 4'(n))};
  endtask

  task automatic read_seq(input int n, input string tag);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      chk(d == ref_mem[cur], tag, d, ref_mem[cur]);
      cur = cur + 11'd1;
    end
    i_stop();
  endtask

  task automatic rand_read(input logic [10:0] a, input int n, input string tag);
    logic ack;
    i_start();
    send_byte({4'b1010, a[10:8], 1'b0}, ack); chk(ack, {tag, " dummy select ack"}, ack, 1);
    send_byte(a[7:0], ack);                   chk(ack, {tag, " dummy addr ack"}, ack, 1);
    i_start();
    send_byte({4'b1010, a[10:8], 1'b1}, ack); chk(ack, {tag, " read select ack"}, ack, 1);
    cur = a;
    read_seq(n, tag);
  endtask

  localparam logic [18:0] VEC [8] = '{
    {11'h000, 8'h3C}, {11'h0FF, 8'hA5}, {11'h100, 8'h00}, {11'h2B7, 8'hFF},
    {11'h455, 8'h81}, {11'h5E0, 8'h7E}, {11'h6C3, 8'h12}, {11'h7FF, 8'hC9}
  };

  logic done = 1'b0;
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int base;
    wq(5);
    chk(!sda_oe && !mem_we && !mem_re, "R1 outputs in reset", {sda_oe, mem_we, mem_re}, 0);
    rst_n = 1'b1;
    wq(20);
    chk(!sda_oe, "R1 idle after reset", sda_oe, 0);

    for (int v = 0; v < 8; v++) begin
      write_run(VEC[v][18:8], VEC[v][7:0], 1, "R2 R3 write");
      chk(mem[VEC[v][18:8]] == VEC[v][7:0], "R3 stored byte", mem[VEC[v][18:8]], VEC[v][7:0]);
      rand_read(VEC[v][18:8], 1, "R6 random read");
    end

    write_run(11'h12E, 8'h40, 4, "R4 row write");
    chk(mem[11'h120] == 8'h42, "R4 wrap to row start", mem[11'h120], 8'h42);
    chk(mem[11'h121] == 8'h43, "R4 second wrapped byte", mem[11'h121], 8'h43);
    chk(mem[11'h130] == ref_mem[11'h130], "R4 next row untouched", mem[11'h130], ref_mem[11'h130]);

    rand_read(11'h333, 1, "R6 random read");
    i_start();
    send_byte(8'hA1, ack); chk(ack, "R5 current select ack", ack, 1);
    read_seq(1, "R5 current read at 334h");

    rand_read(11'h7FE, 3, "R7 sequential wrap");
    chk(cur == 11'h001, "R7 counter after wrap", cur, 1);

    i_start();
    send_byte(8'hB0, ack); chk(!ack, "R2 wrong code not acked", ack, 0);
    send_byte(8'hA0, ack); chk(!ack, "R2 ignored until START", ack, 0);
    i_stop();

    rand_read(11'h050, 1, "R8 setup");
    i_start();
    send_byte(8'hA1, ack); chk(ack, "R8 select ack", ack, 1);
    recv_byte(1'b0, d);
    chk(d == ref_mem[11'h051], "R8 data before refusal", d, ref_mem[11'h051]);
    base = oe_seen;
    for (int i = 0; i < 18; i++) send_bit(1'b1);
    chk(oe_seen == base, "R8 silent after master refusal", oe_seen - base, 0);
    i_stop();
    cur = 11'h052;

    busy = 1'b1;
    i_start();
    send_byte(8'hA0, ack); chk(!ack, "R9 no ack while busy", ack, 0);
    send_byte(8'h10, ack); chk(!ack, "R9 addr ignored while busy", ack, 0);
    i_stop();
    busy = 1'b0;
    wq(4);
    i_start();
    send_byte(8'hA1, ack); chk(ack, "R9 ack after busy clears", ack, 1);
    read_seq(1, "R9 counter unchanged by busy traffic");

    i_start();
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    i_start();
    send_byte(8'hA1, ack); chk(ack, "R10 START mid byte restarts", ack, 1);
    read_seq(1, "R10 read after restart");

    chk(oe_bad == 0, "R11 drive begins with SCL low", oe_bad, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule